// File: doc/BRIEF.md
# Rectangular Blit Transfer Controller

The block sequences a two-dimensional pixel transfer over a rectangle of `ppl_i` pixels per line and `nl_i` lines. Three address streams are kept: foreground source, background source and output destination. Each stream has its own base address, bytes per pixel and line skip. The skip is given in pixels and is applied after the last pixel of every line. The mode picks which streams are fetched. Plain copy and format-converting copy read the foreground only. Blend reads the foreground and then the background. Fill reads nothing and writes a constant colour. Pixel arithmetic is not part of this block: format conversion passes the pixel through unchanged, and blend is stood in for by an alpha-based select.

Software loads the configuration inputs and writes the start bit. `start_o` stays high for as long as the transfer runs and drops by itself when the transfer completes or aborts. Status is held in a six-bit flag register, and bits are cleared by writing ones to the clear port. Memory is reached over one read request channel and one write request channel. Each channel has a request/acknowledge handshake, and the acknowledge carries the response data and an error indication.

Top module: `blit2d_ctrl`

## Requirements
- R1: In modes 0 (copy) and 1 (converting copy), each pixel issues one foreground read (`rd_port_o`=0) and then one write whose data equals the read data. No background read is issued.
- R2: In mode 2 (blend), each pixel issues a foreground read, then a background read (`rd_port_o`=1), then a write. The write data is the foreground word if its top 8 bits are nonzero, and the background word otherwise.
- R3: In mode 3 (fill), no read is issued, and every pixel writes `fill_color_i` as latched at start.
- R4: Pixel i of line j on a stream is at base + (j*(ppl+skip)+i)*bpp. Pixels are visited line by line, left to right.
- R5: An accepted start raises `start_o` on the next cycle. `start_o` falls in the cycle after the last write is acknowledged, and that same cycle sets flag bit 1 (complete).
- R6: A start with `ppl_i`=0 or `nl_i`=0 sets flag bit 5 (configuration error). `start_o` stays low and no request is issued.
- R7: An error on any acknowledge sets flag bit 0 (transfer error), clears `start_o` on the next cycle, and issues no further requests.
- R8: Writing the clear port clears each flag bit whose mask bit is 1 and leaves the others unchanged. A mask of 0x3F clears all six bits. Bits 2 to 4 always read 0.
- R9: At most one request is up at a time. A request stays up with a stable address (and stable data for writes) until it is acknowledged.
- R10: A start written while a transfer runs is ignored. Configuration changes after start have no effect on the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 copy, 1 converting copy, 2 blend, 3 fill |
| fg_base_i | input | 32 | Foreground base byte address |
| bg_base_i | input | 32 | Background base byte address |
| out_base_i | input | 32 | Output base byte address |
| fg_skip_i | input | 14 | Foreground line skip in pixels |
| bg_skip_i | input | 14 | Background line skip in pixels |
| out_skip_i | input | 14 | Output line skip in pixels |
| fg_bpp_i | input | 3 | Foreground bytes per pixel |
| bg_bpp_i | input | 3 | Background bytes per pixel |
| out_bpp_i | input | 3 | Output bytes per pixel |
| ppl_i | input | 14 | Pixels per line |
| nl_i | input | 16 | Number of lines |
| fill_color_i | input | 32 | Constant colour for fill mode |
| start_set_i | input | 1 | Write of one to the start bit |
| flag_clr_we_i | input | 1 | Flag clear write strobe |
| flag_clr_i | input | 6 | Flag clear mask |
| start_o | output | 1 | Start bit, high while busy |
| flags_o | output | 6 | Bit 0 transfer error, bit 1 complete, bit 5 configuration error |
| rd_req_o | output | 1 | Read request |
| rd_port_o | output | 1 | 0 foreground, 1 background |
| rd_addr_o | output | 32 | Read byte address |
| rd_ack_i | input | 1 | Read acknowledge |
| rd_data_i | input | 32 | Read data, valid with acknowledge |
| rd_err_i | input | 1 | Read error, valid with acknowledge |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | 32 | Write byte address |
| wr_data_o | output | 32 | Write data |
| wr_ack_i | input | 1 | Write acknowledge |
| wr_err_i | input | 1 | Write error, valid with acknowledge |

## Verification
The bench aims at line boundaries with nonzero and differing skips and bytes per pixel. A design that applies the skip every pixel, or applies it without the bytes-per-pixel scale, writes to the wrong address on the first pixel of line two. Single-pixel and single-line rectangles catch end-of-line and last-line comparisons that are off by one: such a design either writes past the rectangle or stops one pixel early. Errors are injected on foreground reads, background reads and writes. A design that ignores an error keeps requesting after it. A start that arrives while busy, together with changed configuration, exposes a design that restarts or follows live inputs mid-transfer. Zero-size starts catch a controller that spins or issues a request for an empty rectangle.

// File: rtl/blit2d_pkg.sv
package blit2d_pkg;
  typedef enum logic [1:0] {
    MODE_COPY  = 2'd0,
    MODE_CONV  = 2'd1,
    MODE_BLEND = 2'd2,
    MODE_FILL  = 2'd3
  } blit_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FG   = 2'd1,
    ST_BG   = 2'd2,
    ST_WR   = 2'd3
  } blit_state_e;

  localparam int FLAG_W       = 6;
  localparam int FLAG_XERR    = 0;
  localparam int FLAG_DONE    = 1;
  localparam int FLAG_CFG_ERR = 5;
endpackage

// File: rtl/blit2d_addr_gen.sv
module blit2d_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int SKIP_W = 14,
  parameter int BPP_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [SKIP_W-1:0] skip_i,
  input  logic [BPP_W-1:0]  bpp_i,
  input  logic              step_i,
  input  logic              eol_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int PROD_W = SKIP_W + BPP_W;

  logic [ADDR_W-1:0] addr_q;
  logic [SKIP_W-1:0] skip_q;
  logic [BPP_W-1:0]  bpp_q;
  logic [PROD_W-1:0] line_gap;

  assign line_gap = {{BPP_W{1'b0}}, skip_q} * {{SKIP_W{1'b0}}, bpp_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      skip_q <= '0;
      bpp_q  <= '0;
    end else if (load_i) begin
      addr_q <= base_i;
      skip_q <= skip_i;
      bpp_q  <= bpp_i;
    end else if (step_i) begin
      addr_q <= addr_q + ADDR_W'(bpp_q) + (eol_i ? ADDR_W'(line_gap) : '0);
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/blit2d_scan.sv
module blit2d_scan #(
  parameter int PPL_W = 14,
  parameter int NL_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PPL_W-1:0] ppl_i,
  input  logic [NL_W-1:0]  nl_i,
  input  logic             step_i,
  output logic             eol_o,
  output logic             last_o
);
  logic [PPL_W-1:0] ppl_q, px_q;
  logic [NL_W-1:0]  nl_q, ln_q;

  assign eol_o  = (px_q == ppl_q - 1'b1);
  assign last_o = eol_o && (ln_q == nl_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ppl_q <= '0;
      nl_q  <= '0;
      px_q  <= '0;
      ln_q  <= '0;
    end else if (load_i) begin
      ppl_q <= ppl_i;
      nl_q  <= nl_i;
      px_q  <= '0;
      ln_q  <= '0;
    end else if (step_i) begin
      if (eol_o) begin
        px_q <= '0;
        ln_q <= ln_q + 1'b1;
      end else begin
        px_q <= px_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/blit2d_ctrl.sv
module blit2d_ctrl
  import blit2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SKIP_W = 14,
  parameter int BPP_W  = 3,
  parameter int PPL_W  = 14,
  parameter int NL_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] fg_base_i,
  input  logic [ADDR_W-1:0] bg_base_i,
  input  logic [ADDR_W-1:0] out_base_i,
  input  logic [SKIP_W-1:0] fg_skip_i,
  input  logic [SKIP_W-1:0] bg_skip_i,
  input  logic [SKIP_W-1:0] out_skip_i,
  input  logic [BPP_W-1:0]  fg_bpp_i,
  input  logic [BPP_W-1:0]  bg_bpp_i,
  input  logic [BPP_W-1:0]  out_bpp_i,
  input  logic [PPL_W-1:0]  ppl_i,
  input  logic [NL_W-1:0]   nl_i,
  input  logic [DATA_W-1:0] fill_color_i,
  input  logic              start_set_i,
  input  logic              flag_clr_we_i,
  input  logic [5:0]        flag_clr_i,
  output logic              start_o,
  output logic [5:0]        flags_o,
  output logic              rd_req_o,
  output logic              rd_port_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_err_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ack_i,
  input  logic              wr_err_i
);
  localparam int NPORT     = 3;
  localparam int ALPHA_LSB = DATA_W - 8;

  blit_state_e state_q, state_d;
  blit_mode_e  mode_q;
  logic [DATA_W-1:0] color_q, fg_q, bg_q;
  logic [FLAG_W-1:0] flags_q, flags_set, flags_clr;

  logic accept, zero_dim, launch, rd_done, wr_done, bus_err, pix_step;
  logic eol, last;
  logic [ADDR_W-1:0] base_a [NPORT];
  logic [SKIP_W-1:0] skip_a [NPORT];
  logic [BPP_W-1:0]  bpp_a  [NPORT];
  logic [ADDR_W-1:0] addr_a [NPORT];

  assign base_a[0] = fg_base_i;  assign skip_a[0] = fg_skip_i;  assign bpp_a[0] = fg_bpp_i;
  assign base_a[1] = bg_base_i;  assign skip_a[1] = bg_skip_i;  assign bpp_a[1] = bg_bpp_i;
  assign base_a[2] = out_base_i; assign skip_a[2] = out_skip_i; assign bpp_a[2] = out_bpp_i;

  assign accept   = start_set_i && (state_q == ST_IDLE);
  assign zero_dim = (ppl_i == '0) || (nl_i == '0);
  assign launch   = accept && !zero_dim;
  assign rd_done  = rd_req_o && rd_ack_i;
  assign wr_done  = wr_req_o && wr_ack_i;
  assign bus_err  = (rd_done && rd_err_i) || (wr_done && wr_err_i);
  assign pix_step = wr_done && !wr_err_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    blit2d_addr_gen #(.ADDR_W(ADDR_W), .SKIP_W(SKIP_W), .BPP_W(BPP_W)) u_ag (
      .clk_i, .rst_ni,
      .load_i (launch),
      .base_i (base_a[p]),
      .skip_i (skip_a[p]),
      .bpp_i  (bpp_a[p]),
      .step_i (pix_step),
      .eol_i  (eol),
      .addr_o (addr_a[p])
    );
  end

  blit2d_scan #(.PPL_W(PPL_W), .NL_W(NL_W)) u_scan (
    .clk_i, .rst_ni,
    .load_i (launch),
    .ppl_i, .nl_i,
    .step_i (pix_step),
    .eol_o  (eol),
    .last_o (last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (launch) state_d = (blit_mode_e'(mode_i) == MODE_FILL) ? ST_WR : ST_FG;
      ST_FG:   if (rd_done) state_d = rd_err_i ? ST_IDLE : (mode_q == MODE_BLEND) ? ST_BG : ST_WR;
      ST_BG:   if (rd_done) state_d = rd_err_i ? ST_IDLE : ST_WR;
      ST_WR:   if (wr_done) state_d = (wr_err_i || last) ? ST_IDLE : (mode_q == MODE_FILL) ? ST_WR : ST_FG;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_COPY;
      color_q <= '0;
      fg_q    <= '0;
      bg_q    <= '0;
    end else begin
      state_q <= state_d;
      if (launch) begin
        mode_q  <= blit_mode_e'(mode_i);
        color_q <= fill_color_i;
      end
      if (rd_done && state_q == ST_FG) fg_q <= rd_data_i;
      if (rd_done && state_q == ST_BG) bg_q <= rd_data_i;
    end
  end

  // flags: set wins over a same-cycle clear
  always_comb begin
    flags_set = '0;
    flags_set[FLAG_XERR]    = bus_err;
    flags_set[FLAG_DONE]    = pix_step && last;
    flags_set[FLAG_CFG_ERR] = accept && zero_dim;
    flags_clr = flag_clr_we_i ? flag_clr_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~flags_clr) | flags_set;
  end

  assign start_o   = (state_q != ST_IDLE);
  assign flags_o   = flags_q;
  assign rd_req_o  = (state_q == ST_FG) || (state_q == ST_BG);
  assign rd_port_o = (state_q == ST_BG);
  assign rd_addr_o = (state_q == ST_BG) ? addr_a[1] : addr_a[0];
  assign wr_req_o  = (state_q == ST_WR);
  assign wr_addr_o = addr_a[2];

  always_comb begin
    unique case (mode_q)
      MODE_FILL:  wr_data_o = color_q;
      MODE_BLEND: wr_data_o = (fg_q[DATA_W-1:ALPHA_LSB] != '0) ? fg_q : bg_q;
      default:    wr_data_o = fg_q;
    endcase
  end

  assert_one_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o));
  assert_rd_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o) && $stable(rd_port_o));
  assert_wr_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));
  assert_fill_no_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o && mode_q == MODE_FILL |-> !rd_req_o);
  assert_cfg_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_set_i && !start_o && (ppl_i == '0 || nl_i == '0) |=> !start_o && flags_o[FLAG_CFG_ERR]);
  assert_abort_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && rd_ack_i && rd_err_i) || (wr_req_o && wr_ack_i && wr_err_i)
    |=> !start_o && flags_o[FLAG_XERR]);
  assert_idle_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_o |-> !rd_req_o && !wr_req_o);
  assert_rsvd_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[4:2] == 3'b000);
endmodule

// File: tb/sim_blit2d_ctrl.sv
module sim_blit2d_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]  mode;
  logic [31:0] fg_base, bg_base, out_base, fill_color;
  logic [13:0] fg_skip, bg_skip, out_skip, ppl;
  logic [2:0]  fg_bpp, bg_bpp, out_bpp;
  logic [15:0] nl;
  logic        start_set, clr_we;
  logic [5:0]  clr_mask;
  logic        start, rd_req, rd_port, rd_ack, rd_err, wr_req, wr_ack, wr_err;
  logic [5:0]  flags;
  logic [31:0] rd_addr, rd_data, wr_addr, wr_data;

  int total = 0;
  int bad = 0;

  blit2d_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .fg_base_i(fg_base), .bg_base_i(bg_base), .out_base_i(out_base),
    .fg_skip_i(fg_skip), .bg_skip_i(bg_skip), .out_skip_i(out_skip),
    .fg_bpp_i(fg_bpp), .bg_bpp_i(bg_bpp), .out_bpp_i(out_bpp),
    .ppl_i(ppl), .nl_i(nl), .fill_color_i(fill_color),
    .start_set_i(start_set), .flag_clr_we_i(clr_we), .flag_clr_i(clr_mask),
    .start_o(start), .flags_o(flags),
    .rd_req_o(rd_req), .rd_port_o(rd_port), .rd_addr_o(rd_addr),
    .rd_ack_i(rd_ack), .rd_data_i(rd_data), .rd_err_i(rd_err),
    .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_ack_i(wr_ack), .wr_err_i(wr_err)
  );

  function automatic logic [31:0] fg_val(input logic [31:0] a);
    return {(a[3] ? 8'h00 : 8'hC3), a[23:0] ^ 24'h5A1F3C};
  endfunction
  function automatic logic [31:0] bg_val(input logic [31:0] a);
    return {8'h77, ~a[23:0]};
  endfunction
  function automatic logic [31:0] pix_addr(input logic [31:0] base, input int skp, bpp, pl, j, i);
    return base + 32'((j * (pl + skp) + i) * bpp);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic quiet(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(!rd_req && !wr_req && !start, req, {29'd0, start, rd_req, wr_req}, 32'd0);
    end
  endtask

  task automatic wait_req(input bit is_wr, output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 40 && !seen; k++) begin
      if (is_wr ? wr_req : rd_req) seen = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic serve_rd(input bit port, input logic [31:0] a, input logic [31:0] d, input bit err, input string req);
    bit seen;
    int dly;
    logic [31:0] a0;
    wait_req(1'b0, seen);
    chk(seen, {req, " read request"}, {31'd0, rd_req}, 32'd1);
    chk(rd_port == port, {req, " read port"}, {31'd0, rd_port}, {31'd0, port});
    chk(rd_addr == a, "R4 read address", rd_addr, a);
    chk(!wr_req, "R9 exclusive request", {31'd0, wr_req}, 32'd0);
    a0 = rd_addr;
    dly = $urandom_range(0, 2);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk(rd_req && rd_addr == a0, "R9 read hold", rd_addr, a0);
    end
    rd_ack = 1'b1; rd_data = d; rd_err = err;
    @(negedge clk);
    rd_ack = 1'b0; rd_err = 1'b0; rd_data = 32'hDEAD_BEEF;
  endtask

  task automatic serve_wr(input logic [31:0] a, input logic [31:0] d, input bit err, input string req);
    bit seen;
    int dly;
    wait_req(1'b1, seen);
    chk(seen, {req, " write request"}, {31'd0, wr_req}, 32'd1);
    chk(wr_addr == a, "R4 write address", wr_addr, a);
    chk(wr_data == d, {req, " write data"}, wr_data, d);
    chk(!rd_req, "R9 exclusive request", {31'd0, rd_req}, 32'd0);
    dly = $urandom_range(0, 2);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk(wr_req && wr_addr == a && wr_data == d, "R9 write hold", wr_data, d);
    end
    wr_ack = 1'b1; wr_err = err;
    @(negedge clk);
    wr_ack = 1'b0; wr_err = 1'b0;
  endtask

  task automatic pulse_start();
    start_set = 1'b1;
    @(negedge clk);
    start_set = 1'b0;
  endtask

  task automatic clear_flags(input logic [5:0] m);
    clr_we = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_we = 1'b0; clr_mask = '0;
  endtask

  // err_at: transaction index that gets an error response, -1 for none
  task automatic run_xfer(input int md, input int pl, input int nls,
                          input logic [31:0] fb, input logic [31:0] bb, input logic [31:0] ob,
                          input int fs, input int bs, input int os,
                          input int fp, input int bp, input int op,
                          input logic [31:0] col, input int err_at, input bit disturb);
    int idx = 0;
    string rq;
    logic [31:0] fa, ba, oa, fv, bv, ev;
    rq = (md == 3) ? "R3" : (md == 2) ? "R2" : "R1";
    clear_flags(6'h3F);
    mode = 2'(md); ppl = 14'(pl); nl = 16'(nls);
    fg_base = fb; bg_base = bb; out_base = ob;
    fg_skip = 14'(fs); bg_skip = 14'(bs); out_skip = 14'(os);
    fg_bpp = 3'(fp); bg_bpp = 3'(bp); out_bpp = 3'(op);
    fill_color = col;
    pulse_start();
    chk(start, "R5 start rises", {31'd0, start}, 32'd1);
    if (disturb) begin
      mode = ~mode; fg_base = ~fb; bg_base = ~bb; out_base = ~ob;
      ppl = 14'd9; nl = 16'd9; fill_color = ~col; fg_skip = 14'd3; out_bpp = 3'd1;
      pulse_start();
      chk(start, "R10 start while busy", {31'd0, start}, 32'd1);
    end
    for (int j = 0; j < nls; j++) begin
      for (int i = 0; i < pl; i++) begin
        fa = pix_addr(fb, fs, fp, pl, j, i);
        ba = pix_addr(bb, bs, bp, pl, j, i);
        oa = pix_addr(ob, os, op, pl, j, i);
        fv = fg_val(fa);
        bv = bg_val(ba);
        if (md != 3) begin
          serve_rd(1'b0, fa, fv, idx == err_at, rq);
          if (idx == err_at) begin
            chk(!start && flags[0], "R7 abort on fg read", {26'd0, flags}, 32'h1);
            quiet(3, "R7 no requests after abort");
            return;
          end
          idx++;
        end
        if (md == 2) begin
          serve_rd(1'b1, ba, bv, idx == err_at, rq);
          if (idx == err_at) begin
            chk(!start && flags[0], "R7 abort on bg read", {26'd0, flags}, 32'h1);
            quiet(3, "R7 no requests after abort");
            return;
          end
          idx++;
        end
        ev = (md == 3) ? col : (md == 2) ? ((fv[31:24] != 8'h00) ? fv : bv) : fv;
        serve_wr(oa, ev, idx == err_at, rq);
        if (idx == err_at) begin
          chk(!start && flags[0], "R7 abort on write", {26'd0, flags}, 32'h1);
          quiet(3, "R7 no requests after abort");
          return;
        end
        idx++;
        if (!(j == nls - 1 && i == pl - 1))
          chk(start, "R5 busy mid transfer", {31'd0, start}, 32'd1);
      end
    end
    chk(!start && flags == 6'b000010, "R5 completion", {26'd0, flags, start}, 32'h4);
    quiet(2, "R5 quiet after completion");
  endtask

  initial begin
    int s;
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=finished");
    total++; bad++;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h0BAD_5EED);
    mode = '0; fg_base = '0; bg_base = '0; out_base = '0; fill_color = '0;
    fg_skip = '0; bg_skip = '0; out_skip = '0; ppl = '0; nl = '0;
    fg_bpp = 3'd4; bg_bpp = 3'd4; out_bpp = 3'd4;
    start_set = 0; clr_we = 0; clr_mask = '0;
    rd_ack = 0; rd_err = 0; rd_data = '0; wr_ack = 0; wr_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!start && flags == 6'd0 && !rd_req && !wr_req, "R5 reset state",
        {25'd0, flags, start}, 32'd0);

    // directed modes
    run_xfer(0, 3, 2, 32'h1000, 32'h0, 32'h8000, 2, 0, 5, 4, 4, 4, 32'h0, -1, 0);
    run_xfer(1, 2, 3, 32'h2001, 32'h0, 32'h9000, 1, 0, 0, 2, 2, 4, 32'h0, -1, 0);
    run_xfer(2, 3, 2, 32'h3000, 32'hA000, 32'hA000, 4, 1, 1, 4, 4, 4, 32'h0, -1, 0);
    run_xfer(3, 4, 3, 32'h0, 32'h0, 32'hB010, 0, 0, 3, 1, 1, 2, 32'hCAFE_F00D, -1, 0);
    // single pixel and single line / single column
    run_xfer(2, 1, 1, 32'h0, 32'h8, 32'h8, 7, 7, 7, 3, 3, 3, 32'h0, -1, 0);
    run_xfer(0, 5, 1, 32'h40, 32'h0, 32'h400, 9, 0, 9, 1, 1, 3, 32'h0, -1, 0);
    run_xfer(3, 1, 4, 32'h0, 32'h0, 32'hFFFF_FFF0, 0, 0, 2, 1, 1, 4, 32'h1234_5678, -1, 0);
    // busy restart and config change ignored (R10)
    run_xfer(1, 3, 2, 32'h5000, 32'h0, 32'h6000, 1, 0, 2, 4, 4, 4, 32'h0, -1, 1);
    run_xfer(3, 2, 2, 32'h0, 32'h0, 32'h7000, 0, 0, 1, 1, 1, 4, 32'h0F0F_0F0F, -1, 1);
    // error responses (R7)
    run_xfer(0, 3, 2, 32'h1000, 32'h0, 32'h8000, 0, 0, 0, 4, 4, 4, 32'h0, 4, 0);
    run_xfer(2, 2, 2, 32'h1000, 32'h2000, 32'h2000, 0, 0, 0, 4, 4, 4, 32'h0, 4, 0);
    run_xfer(3, 3, 2, 32'h0, 32'h0, 32'h3000, 0, 0, 0, 4, 4, 4, 32'h55, 2, 0);

    // zero sizes (R6)
    clear_flags(6'h3F);
    ppl = 14'd0; nl = 16'd3;
    pulse_start();
    chk(!start && flags[5], "R6 zero ppl", {26'd0, flags}, 32'h20);
    quiet(3, "R6 no requests");
    clear_flags(6'h3F);
    ppl = 14'd4; nl = 16'd0;
    pulse_start();
    chk(!start && flags[5], "R6 zero nl", {26'd0, flags}, 32'h20);
    quiet(3, "R6 no requests");

    // write-one-to-clear (R8): build flags 0x23
    run_xfer(3, 1, 1, 32'h0, 32'h0, 32'h100, 0, 0, 0, 4, 4, 4, 32'h1, -1, 0);
    mode = 2'd3; ppl = 14'd1; nl = 16'd1;
    pulse_start();
    serve_wr(32'h100, fill_color, 1'b1, "R7");
    ppl = 14'd0;
    pulse_start();
    chk(flags == 6'h23, "R8 flags before clear", {26'd0, flags}, 32'h23);
    clear_flags(6'h02);
    chk(flags == 6'h21, "R8 partial clear", {26'd0, flags}, 32'h21);
    clear_flags(6'h1C);
    chk(flags == 6'h21, "R8 reserved mask no effect", {26'd0, flags}, 32'h21);
    clear_flags(6'h3F);
    chk(flags == 6'h00, "R8 full clear", {26'd0, flags}, 32'h0);

    // constrained random transfers
    for (int n = 0; n < 24; n++) begin
      int md, e;
      logic [31:0] ob;
      md = $urandom_range(0, 3);
      ob = $urandom;
      e = ($urandom_range(0, 4) == 0) ? $urandom_range(0, 3) : -1;
      run_xfer(md, $urandom_range(1, 4), $urandom_range(1, 3),
               $urandom, $urandom, (md == 2) ? ob : $urandom & 32'hFFFF_0000 | ob[15:0],
               $urandom_range(0, 5), $urandom_range(0, 5), $urandom_range(0, 5),
               $urandom_range(1, 4), $urandom_range(1, 4), $urandom_range(1, 4),
               $urandom, e, n[2]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule